// File: doc/BRIEF.md
# Multi-Mode Aligned PWM Generator

This block drives a single PWM output from one period counter. The counter either runs downward from the period value to zero and reloads, or runs as a triangle from zero up to the period value and back. The output level comes from comparing the counter with one or two threshold values. Four shapes are available: a pulse that starts at the start of each period (left), a pulse that ends at the end of each period (right), a pulse centred in a triangle period (center), and a pulse with both edges placed freely (dual). The dual shape is the AND of a left term and a right term.

Software-side writes go through a small write port into shadow copies of the period, both thresholds and the shape. The live copies take the shadow values only when the counter passes zero, so a running period is never cut short or reshaped halfway. While the block is disabled, the live copies follow the shadow copies every cycle. The counter also shows the live count and gives a pulse in each cycle where the count sits at zero.

Top module: `pwm_align_gen`

## Requirements
- R1: After reset, cnt_o is 0, pwm_o is 0 and zero_o is 0.
- R2: A write with wr_en high stores wr_data into a shadow slot chosen by wr_addr: 0 = period, 1 = threshold A, 2 = threshold B, 3 = shape in wr_data[1:0] (0 = left, 1 = right, 2 = center, 3 = dual).
- R3: While en is low, pwm_o and zero_o are 0, the shadow values become live on the next edge, and cnt_o holds the period value for the left, right and dual shapes and 0 for the center shape.
- R4: In the left, right and dual shapes, each enabled edge moves cnt_o from P down by one per cycle to 0 and then back to P, giving a period of P+1 cycles.
- R5: In the center shape, each enabled edge steps cnt_o by one from 0 up to P and back down to 0, giving a period of 2*P cycles (with P = 0 the count stays at 0).
- R6: Left shape: pwm_o is 1 exactly when cnt_o > A.
- R7: Right shape: pwm_o is 1 exactly when cnt_o <= A.
- R8: Center shape: while rising (including the cycle at P), pwm_o is 1 exactly when cnt_o >= A; while falling (including the cycle back at 0), pwm_o is 1 exactly when cnt_o > A.
- R9: Dual shape: pwm_o is 1 exactly when A < cnt_o <= B, so it stays 0 for the whole period when A >= B.
- R10: Writes made while enabled change nothing in the current period; the new period, thresholds and shape apply from the cycle after cnt_o shows 0.
- R11: zero_o is 1 exactly in the cycles where cnt_o is 0 and the preceding edge was enabled.
- R12: A threshold A above the period value gives a constant level with no toggling: always 0 in the left shape and always 1 in the right shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counter and forces the output low |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 2 | Shadow slot select |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output, registered |
| cnt_o | output | CNT_W | Live counter value |
| zero_o | output | 1 | High in each running cycle with the counter at zero |

## Verification
Each shape is run over several full periods with threshold pairs that sit inside the period, at its edges and past it. A fault in a comparison direction or in the strictness of a bound then shows up as a one-count shift of an edge. Center runs use a threshold of 0 and a mid value, which separates the rising and falling rules at the turn-around points. Dual runs with A below B and with A at or above B tell the AND of the two terms apart from either term alone. Writes injected a few cycles before zero, including a shape change from left to center, show whether the live values change only at the reload.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;

    // Output shape selection; the value is the one written to the shape slot
    typedef enum logic [1:0] {
        ALN_LEFT   = 2'd0,
        ALN_RIGHT  = 2'd1,
        ALN_CENTER = 2'd2,
        ALN_DUAL   = 2'd3
    } align_e;

    // Shadow slot addresses on the write port
    localparam logic [1:0] SLOT_PERIOD = 2'd0;
    localparam logic [1:0] SLOT_THR_A  = 2'd1;
    localparam logic [1:0] SLOT_THR_B  = 2'd2;
    localparam logic [1:0] SLOT_SHAPE  = 2'd3;

    // Number of data words held in the shadow bank (period, A, B)
    localparam int unsigned NUM_WORDS = 3;

    // Triangle counting is used only by the center shape
    function automatic logic is_triangle(input align_e m);
        return (m == ALN_CENTER);
    endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] sh_period,
    output logic [W-1:0] sh_thr_a,
    output logic [W-1:0] sh_thr_b,
    output align_e       sh_shape
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][W-1:0] word;
        align_e                      shape;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int i = 0; i < int'(NUM_WORDS); i++) begin
                if (wr_addr == 2'(i)) begin
                    s_d.word[i] = wr_data;
                end
            end
            if (wr_addr == SLOT_SHAPE) begin
                s_d.shape = align_e'(wr_data[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{word: '0, shape: ALN_LEFT};
        end else begin
            s_q <= s_d;
        end
    end

    assign sh_period = s_q.word[SLOT_PERIOD];
    assign sh_thr_a  = s_q.word[SLOT_THR_A];
    assign sh_thr_b  = s_q.word[SLOT_THR_B];
    assign sh_shape  = s_q.shape;

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] sh_period,
    input  logic [W-1:0] sh_thr_a,
    input  logic [W-1:0] sh_thr_b,
    input  align_e       sh_shape,
    // next-state view, used by the output stage so it lines up with cnt
    output logic [W-1:0] nx_cnt,
    output logic         nx_up,
    output logic [W-1:0] nx_thr_a,
    output logic [W-1:0] nx_thr_b,
    output align_e       nx_shape,
    // registered view
    output logic [W-1:0] cur_cnt,
    output logic [W-1:0] cur_period,
    output align_e       cur_shape
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic [W-1:0] period;
        logic [W-1:0] thr_a;
        logic [W-1:0] thr_b;
        align_e       shape;
    } ctr_t;

    ctr_t c_d, c_q;
    logic at_zero;
    logic at_peak;

    assign at_zero = (c_q.cnt == '0);
    assign at_peak = c_q.up && (c_q.cnt >= c_q.period);

    always_comb begin
        c_d = c_q;
        if (!en) begin
            // idle: follow shadow values and park at the shape's start point
            c_d.period = sh_period;
            c_d.thr_a  = sh_thr_a;
            c_d.thr_b  = sh_thr_b;
            c_d.shape  = sh_shape;
            c_d.up     = is_triangle(sh_shape);
            c_d.cnt    = is_triangle(sh_shape) ? '0 : sh_period;
        end else if (at_zero) begin
            // period boundary: take the shadow values
            c_d.period = sh_period;
            c_d.thr_a  = sh_thr_a;
            c_d.thr_b  = sh_thr_b;
            c_d.shape  = sh_shape;
            if (is_triangle(sh_shape)) begin
                c_d.up  = 1'b1;
                c_d.cnt = (sh_period == '0) ? '0 : ONE;
            end else begin
                c_d.up  = 1'b0;
                c_d.cnt = sh_period;
            end
        end else if (is_triangle(c_q.shape)) begin
            if (at_peak) begin
                c_d.up  = 1'b0;
                c_d.cnt = c_q.cnt - ONE;
            end else if (c_q.up) begin
                c_d.cnt = c_q.cnt + ONE;
            end else begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end else begin
            c_d.cnt = c_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{cnt: '0, up: 1'b0, period: '0, thr_a: '0, thr_b: '0,
                     shape: ALN_LEFT};
        end else begin
            c_q <= c_d;
        end
    end

    assign nx_cnt     = c_d.cnt;
    assign nx_up      = c_d.up;
    assign nx_thr_a   = c_d.thr_a;
    assign nx_thr_b   = c_d.thr_b;
    assign nx_shape   = c_d.shape;
    assign cur_cnt    = c_q.cnt;
    assign cur_period = c_q.period;
    assign cur_shape  = c_q.shape;

endmodule

// File: rtl/pwm_edge_compare.sv
module pwm_edge_compare
    import pwm_align_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic [W-1:0] thr_a,
    input  logic [W-1:0] thr_b,
    input  align_e       shape,
    output logic         pwm_o,
    output logic         zero_o
);

    typedef struct packed {
        logic pwm;
        logic zero;
    } out_t;

    out_t o_d, o_q;

    logic above_a;     // left term with A
    logic atmost_a;    // right term with A
    logic atmost_b;    // right term with B
    logic center_hi;
    logic level;

    always_comb begin
        above_a   = (cnt > thr_a);
        atmost_a  = !above_a;
        atmost_b  = (cnt <= thr_b);
        center_hi = up ? (cnt >= thr_a) : above_a;
        unique case (shape)
            ALN_LEFT:   level = above_a;
            ALN_RIGHT:  level = atmost_a;
            ALN_CENTER: level = center_hi;
            ALN_DUAL:   level = above_a && atmost_b;
            default:    level = 1'b0;
        endcase
    end

    always_comb begin
        o_d.pwm  = en && level;
        o_d.zero = en && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign pwm_o  = o_q.pwm;
    assign zero_o = o_q.zero;

endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen
    import pwm_align_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] sh_period, sh_thr_a, sh_thr_b;
    align_e           sh_shape;

    logic [CNT_W-1:0] nx_cnt, nx_thr_a, nx_thr_b;
    logic             nx_up;
    align_e           nx_shape;

    logic [CNT_W-1:0] cur_cnt, cur_period;
    align_e           cur_shape;

    pwm_shadow_bank #(.W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sh_period (sh_period),
        .sh_thr_a  (sh_thr_a),
        .sh_thr_b  (sh_thr_b),
        .sh_shape  (sh_shape)
    );

    pwm_period_counter #(.W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sh_period  (sh_period),
        .sh_thr_a   (sh_thr_a),
        .sh_thr_b   (sh_thr_b),
        .sh_shape   (sh_shape),
        .nx_cnt     (nx_cnt),
        .nx_up      (nx_up),
        .nx_thr_a   (nx_thr_a),
        .nx_thr_b   (nx_thr_b),
        .nx_shape   (nx_shape),
        .cur_cnt    (cur_cnt),
        .cur_period (cur_period),
        .cur_shape  (cur_shape)
    );

    pwm_edge_compare #(.W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .cnt    (nx_cnt),
        .up     (nx_up),
        .thr_a  (nx_thr_a),
        .thr_b  (nx_thr_b),
        .shape  (nx_shape),
        .pwm_o  (pwm_o),
        .zero_o (zero_o)
    );

    assign cnt_o = cur_cnt;

endmodule

// File: rtl/pwm_align_chk.sv
module pwm_align_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         pwm_o,
    input logic [W-1:0] cnt_o,
    input logic         zero_o,
    input logic [1:0]   shape_q,
    input logic [W-1:0] period_q
);

    localparam logic [1:0] SHAPE_CENTER = 2'd2;

    // R11
    zero_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (cnt_o == '0));

    // R11
    zero_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (cnt_o == '0)) |-> zero_o);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!pwm_o && !zero_o));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (shape_q != SHAPE_CENTER) && ($past(cnt_o) != '0))
        |-> (cnt_o == W'($past(cnt_o) - 1'b1)));

    // R5
    tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (shape_q == SHAPE_CENTER))
        |-> (({1'b0, cnt_o} == {1'b0, $past(cnt_o)} + 1'b1)
          || ({1'b0, cnt_o} + 1'b1 == {1'b0, $past(cnt_o)})
          || ((cnt_o == '0) && ($past(cnt_o) == '0))));

    // R4
    within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= period_q);

endmodule

bind pwm_align_gen pwm_align_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pwm_o    (pwm_o),
    .cnt_o    (cnt_o),
    .zero_o   (zero_o),
    .shape_q  (cur_shape),
    .period_q (cur_period)
);

// File: tb/pwm_align_gen_test.sv
`timescale 1ns/1ps
module pwm_align_gen_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o;
    logic [W-1:0] cnt_o;
    logic         zero_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model state
    int m_shape, m_per, m_a, m_b, m_cnt;
    bit m_up;
    int p_shape, p_per, p_a, p_b;

    always #2 clk = ~clk;

    pwm_align_gen #(.CNT_W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .cnt_o   (cnt_o),
        .zero_o  (zero_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_level();
        case (m_shape)
            0: return m_cnt > m_a;
            1: return m_cnt <= m_a;
            2: return m_up ? (m_cnt >= m_a) : (m_cnt > m_a);
            default: return (m_cnt > m_a) && (m_cnt <= m_b);
        endcase
    endfunction

    task automatic model_step();
        if (m_cnt == 0) begin
            m_shape = p_shape; m_per = p_per; m_a = p_a; m_b = p_b;
            if (m_shape == 2) begin
                m_up = 1'b1;
                m_cnt = (m_per == 0) ? 0 : 1;
            end else begin
                m_up = 1'b0;
                m_cnt = m_per;
            end
        end else if (m_shape == 2) begin
            if (m_up && m_cnt >= m_per) begin
                m_up = 1'b0;
                m_cnt = m_cnt - 1;
            end else if (m_up) m_cnt = m_cnt + 1;
            else m_cnt = m_cnt - 1;
        end else begin
            m_cnt = m_cnt - 1;
        end
    endtask

    task automatic note_write(input logic [1:0] a, input int d);
        case (a)
            2'd0: p_per = d;
            2'd1: p_a = d;
            2'd2: p_b = d;
            default: p_shape = d % 4;
        endcase
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2 R3: load shadow slots while idle, check the parked state
    task automatic configure(input int shape, input int per, input int a, input int b);
        en = 1'b0;
        wr(2'd0, per);
        wr(2'd1, a);
        wr(2'd2, b);
        wr(2'd3, shape);
        @(negedge clk);
        p_shape = shape; p_per = per; p_a = a; p_b = b;
        m_shape = shape; m_per = per; m_a = a; m_b = b;
        m_up = (shape == 2);
        m_cnt = (shape == 2) ? 0 : per;
        chk("R3 idle count", int'(cnt_o), m_cnt);
        chk("R3 idle pwm", int'(pwm_o), 0);
        chk("R3 idle zero", int'(zero_o), 0);
    endtask

    task automatic run(input int ncyc, input string tag_cnt, input string tag_pwm,
                       input int inj_at, input logic [1:0] ia1, input int id1,
                       input logic [1:0] ia2, input int id2);
        en = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            bit wrote = 1'b0;
            logic [1:0] wa = '0;
            int wd = 0;
            if (inj_at >= 0 && i == inj_at) begin
                wrote = 1'b1; wa = ia1; wd = id1;
            end else if (inj_at >= 0 && i == inj_at + 1) begin
                wrote = 1'b1; wa = ia2; wd = id2;
            end
            wr_en = wrote; wr_addr = wa; wr_data = W'(wd);
            @(posedge clk);
            model_step();
            if (wrote) note_write(wa, wd);
            @(negedge clk);
            wr_en = 1'b0;
            chk(tag_cnt, int'(cnt_o), m_cnt);
            chk(tag_pwm, int'(pwm_o), int'(exp_level()));
            chk("R11 zero pulse", int'(zero_o), int'(m_cnt == 0));
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset count", int'(cnt_o), 0);
        chk("R1 reset pwm", int'(pwm_o), 0);
        chk("R1 reset zero", int'(zero_o), 0);
    endtask

    task automatic t_left();
        configure(0, 7, 3, 0);
        run(24, "R4 down count", "R6 left", -1, 2'd0, 0, 2'd0, 0);
    endtask

    task automatic t_right();
        configure(1, 6, 2, 0);
        run(21, "R4 down count", "R7 right", -1, 2'd0, 0, 2'd0, 0);
        configure(1, 4, 0, 0);
        run(10, "R4 down count", "R7 right A=0", -1, 2'd0, 0, 2'd0, 0);
    endtask

    task automatic t_center();
        configure(2, 5, 2, 0);
        run(25, "R5 triangle", "R8 center", -1, 2'd0, 0, 2'd0, 0);
        configure(2, 4, 0, 0);
        run(17, "R5 triangle", "R8 center A=0", -1, 2'd0, 0, 2'd0, 0);
        configure(2, 3, 3, 0);
        run(12, "R5 triangle", "R8 center A=P", -1, 2'd0, 0, 2'd0, 0);
    endtask

    task automatic t_dual();
        configure(3, 10, 3, 7);
        run(33, "R4 down count", "R9 dual A<B", -1, 2'd0, 0, 2'd0, 0);
        configure(3, 10, 6, 4);
        run(22, "R4 down count", "R9 dual A>=B", -1, 2'd0, 0, 2'd0, 0);
    endtask

    task automatic t_over();
        configure(0, 5, 9, 0);
        run(18, "R4 down count", "R12 left over", -1, 2'd0, 0, 2'd0, 0);
        configure(1, 5, 9, 0);
        run(18, "R4 down count", "R12 right over", -1, 2'd0, 0, 2'd0, 0);
    endtask

    task automatic t_shadow();
        // period and threshold written two and three counts before zero
        configure(0, 5, 2, 0);
        run(30, "R10 shadow count", "R10 shadow pwm", 2, 2'd0, 8, 2'd1, 6);
        // shape switch from left to center mid-period
        configure(0, 4, 1, 0);
        run(24, "R10 shape count", "R10 shape pwm", 1, 2'd3, 2, 2'd1, 2);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_left();
        t_right();
        t_center();
        t_dual();
        t_over();
        t_shadow();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule